// File: doc/BRIEF.md
# Addressed serial slave front end with pause

This block is the bit-level receive and transmit stage of a small addressable register device on a four-wire serial bus. The clock, data-in, select and pause pins are brought into the system clock through short synchroniser chains. Bus edges are found there, so the block has no second clock domain. Data-in is captured on each rising bus clock edge, most significant bit first. The data-out register changes on each falling edge.

The first byte of every selection is the identification byte. Its upper nibble must equal a fixed device-type code (default 0101). The next two bits must be zero. The two low bits must equal the two strap pins. When the byte matches, the block raises a match flag. It then reports every complete byte with its position in the sequence, and every single bit after the identification byte, for commands of open length. It also shifts a byte supplied by the command engine out on the data-out pin. When the byte does not match, the block stays silent for the rest of the selection.

A pause pin lets the host freeze a transfer without losing its place. Raising select at any moment ends the sequence and gives the command engine a one-cycle pulse.

Top module: `spi_id_frontend`

## Requirements
- R1: While csn is high, sdo_oe is 0, and bus clock pulses produce no rx_valid and no bit_stb. After reset sdo_oe, rx_valid, bit_stb and cs_rise are 0.
- R2: After reset, no transfer is decoded until csn has been seen high and then low. A selection that is already low when reset is released gives no strobes, no match and no cs_rise.
- R3: Data-in is sampled at each rising sck edge, MSB first. After every 8th sampled bit of an accepted sequence, rx_valid pulses for one cycle. rx_byte then holds the byte and byte_idx holds its position, counting from 0 for the identification byte.
- R4: An identification byte equal to {TYPE_ID, 2'b00, strap_addr[1:0]}, sent MSB first, sets addr_match. It also gives an rx_valid pulse with byte_idx 0.
- R5: Any other identification byte leaves addr_match at 0, whether the address, the type nibble or a reserved bit differs. For the rest of that selection there is no rx_valid, no bit_stb and sdo_oe stays 0.
- R6: After a matching identification byte, each further sampled bit, including the bits of an unfinished last byte, gives a one-cycle bit_stb with bit_val equal to that bit.
- R7: At the completion of each accepted byte, tx_data is captured. On the next eight falling sck edges it appears on sdo, MSB first. sdo_oe is 1 while the selection is matched and not paused.
- R8: holdn seen low while sck is low pauses the transfer. Bus clock edges during the pause are ignored, and the bit position and shift state are kept. holdn seen high while sck is low resumes the transfer.
- R9: While paused, sdo_oe is 0.
- R10: csn going high ends the sequence at any bit and clears the bit and byte position. While a selection was in progress, it raises cs_rise for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sck | input | 1 | Bus clock |
| sdi | input | 1 | Bus data in |
| csn | input | 1 | Active-low select |
| holdn | input | 1 | Active-low pause |
| strap_addr | input | 2 | Strapped device address |
| tx_data | input | 8 | Byte to send, captured at each accepted byte end |
| sdo | output | 1 | Bus data out value |
| sdo_oe | output | 1 | Drive enable for sdo (0 means high impedance) |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_byte |
| byte_idx | output | IDX_W | Position of rx_byte in the sequence (saturating) |
| addr_match | output | 1 | Identification byte accepted in this selection |
| bit_val | output | 1 | Value of the reported bit |
| bit_stb | output | 1 | One-cycle strobe for each bit after the identification byte |
| cs_rise | output | 1 | One-cycle pulse when a selection ends |

## Verification
The bench builds the block with its default parameters: type code 0101, two synchroniser stages and a four-bit byte index. Frames are at most six bytes long, so the index never reaches saturation. The bench holds each bus clock phase for eight system clocks. That covers the three-cycle path from a bus edge to the output, so data-out can be checked at every rising bus edge. It can also check that a rising edge followed by a falling edge during a pause is ignored. Random straps, identification bytes, frame lengths, partial trailing bytes and pause points bring the match and reject paths within reach, together with aborts in mid-byte and pauses that start inside the identification byte.

// File: rtl/spi_id_frontend.sv
module spi_id_frontend #(
  parameter logic [3:0] TYPE_ID     = 4'b0101,
  parameter int         SYNC_STAGES = 2,
  parameter int         IDX_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck,
  input  logic             sdi,
  input  logic             csn,
  input  logic             holdn,
  input  logic [1:0]       strap_addr,
  input  logic [7:0]       tx_data,
  output logic             sdo,
  output logic             sdo_oe,
  output logic [7:0]       rx_byte,
  output logic             rx_valid,
  output logic [IDX_W-1:0] byte_idx,
  output logic             addr_match,
  output logic             bit_val,
  output logic             bit_stb,
  output logic             cs_rise
);

  localparam int               BITS    = 8;
  localparam int               CNT_W   = $clog2(BITS);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(BITS - 1);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [SYNC_STAGES-1:0] sck_p, sdi_p, csn_p, hold_p;
  logic sck_d, csn_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p  <= '0;
      sdi_p  <= '0;
      csn_p  <= '0;
      hold_p <= '1;
      sck_d  <= 1'b0;
      csn_d  <= 1'b0;
    end else begin
      sck_p  <= {sck_p[SYNC_STAGES-2:0], sck};
      sdi_p  <= {sdi_p[SYNC_STAGES-2:0], sdi};
      csn_p  <= {csn_p[SYNC_STAGES-2:0], csn};
      hold_p <= {hold_p[SYNC_STAGES-2:0], holdn};
      sck_d  <= sck_p[SYNC_STAGES-1];
      csn_d  <= csn_p[SYNC_STAGES-1];
    end
  end

  logic sck_s, sdi_s, csn_s, hold_s;
  assign sck_s  = sck_p[SYNC_STAGES-1];
  assign sdi_s  = sdi_p[SYNC_STAGES-1];
  assign csn_s  = csn_p[SYNC_STAGES-1];
  assign hold_s = hold_p[SYNC_STAGES-1];

  logic sck_rise, sck_fall, cs_fall;
  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign cs_fall  = ~csn_s & csn_d;

  logic             started, held;
  logic [CNT_W-1:0] bit_cnt;
  logic [IDX_W-1:0] idx;
  logic [7:0]       rx_sh, tx_sh, next_sh;
  logic             sdo_r, id_ok;

  assign next_sh = {rx_sh[6:0], sdi_s};
  assign id_ok   = (next_sh == {TYPE_ID, 2'b00, strap_addr});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started    <= 1'b0;
      held       <= 1'b0;
      bit_cnt    <= '0;
      idx        <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      sdo_r      <= 1'b0;
      addr_match <= 1'b0;
      rx_byte    <= '0;
      rx_valid   <= 1'b0;
      byte_idx   <= '0;
      bit_val    <= 1'b0;
      bit_stb    <= 1'b0;
      cs_rise    <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      bit_stb  <= 1'b0;
      cs_rise  <= 1'b0;
      if (csn_s) begin
        cs_rise    <= started;
        started    <= 1'b0;
        held       <= 1'b0;
        bit_cnt    <= '0;
        idx        <= '0;
        tx_sh      <= '0;
        sdo_r      <= 1'b0;
        addr_match <= 1'b0;
      end else begin
        if (cs_fall) started <= 1'b1;
        if (!sck_s) held <= ~hold_s;
        if (started && !held) begin
          if (sck_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
            rx_sh   <= next_sh;
            if (idx != '0 && addr_match) begin
              bit_stb <= 1'b1;
              bit_val <= sdi_s;
            end
            if (bit_cnt == LAST) begin
              if (idx == '0) addr_match <= id_ok;
              if ((idx == '0) ? id_ok : addr_match) begin
                rx_valid <= 1'b1;
                rx_byte  <= next_sh;
                byte_idx <= idx;
                tx_sh    <= tx_data;
              end
              if (idx != IDX_MAX) idx <= idx + 1'b1;
            end
          end
          if (sck_fall && addr_match) begin
            sdo_r <= tx_sh[7];
            tx_sh <= {tx_sh[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign sdo    = sdo_r;
  assign sdo_oe = started & ~csn_s & ~held & addr_match;

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R3

  AST_ID_STROBE_MATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && byte_idx == '0) |-> addr_match); // R4

  AST_BIT_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> addr_match); // R6

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (held && $past(held)) |-> ($stable(bit_cnt) && $stable(rx_sh))); // R8

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |-> (bit_cnt == '0 && idx == '0 && !addr_match)); // R10

  AST_CSRISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !cs_rise); // R10

endmodule

// File: tb/sim_spi_id_frontend.sv
module sim_spi_id_frontend;
  localparam int HP = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, sck, sdi, csn, holdn;
  logic [1:0] strap_addr;
  logic [7:0] tx_data;
  logic sdo, sdo_oe, rx_valid, addr_match, bit_val, bit_stb, cs_rise;
  logic [7:0] rx_byte;
  logic [3:0] byte_idx;

  spi_id_frontend u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .csn(csn), .holdn(holdn),
    .strap_addr(strap_addr), .tx_data(tx_data), .sdo(sdo), .sdo_oe(sdo_oe),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .byte_idx(byte_idx),
    .addr_match(addr_match), .bit_val(bit_val), .bit_stb(bit_stb), .cs_rise(cs_rise)
  );

  int errors = 0;
  int checks = 0;

  logic [7:0] mon_b [0:255];
  logic [3:0] mon_i [0:255];
  logic       mon_bits [0:2047];
  int n_rx = 0, n_bits = 0, n_csr = 0;

  always @(negedge clk) begin
    if (rx_valid) begin
      mon_b[n_rx % 256] <= rx_byte;
      mon_i[n_rx % 256] <= byte_idx;
      n_rx <= n_rx + 1;
    end
    if (bit_stb) begin
      mon_bits[n_bits % 2048] <= bit_val;
      n_bits <= n_bits + 1;
    end
    if (cs_rise) n_csr <= n_csr + 1;
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic exp_match(logic [7:0] id, logic [1:0] a);
    return id == {4'b0101, 2'b00, a};
  endfunction

  task automatic sck_pulse(logic b, output logic so, output logic oe);
    sdi = b;
    wclk(HP);
    sck = 1'b1;
    so  = sdo;
    oe  = sdo_oe;
    wclk(HP);
    sck = 1'b0;
  endtask

  task automatic do_hold();
    wclk(2);
    holdn = 1'b0;
    wclk(HP);
    chk("R9", "sdo_oe while paused", sdo_oe, 0);
    sdi = ~sdi;
    for (int k = 0; k < 3; k++) begin
      sck = 1'b1; wclk(HP);
      sck = 1'b0; wclk(HP);
    end
    holdn = 1'b1;
    wclk(HP);
  endtask

  logic [7:0] tbytes [0:15];
  logic       xbits  [0:7];
  logic       sob    [0:255];
  logic       soe    [0:255];

  task automatic frame(int n, int extra, int hold_at, logic [1:0] strap, logic [7:0] txd);
    int br, bb, bc, total, nb;
    logic m, bitv, so, oe;
    strap_addr = strap;
    tx_data    = txd;
    br = n_rx; bb = n_bits; bc = n_csr;
    m = exp_match(tbytes[0], strap);
    total = 8 * n + extra;
    csn = 1'b0;
    wclk(HP);
    for (int b = 0; b < total; b++) begin
      if (b == hold_at) do_hold();
      bitv = (b < 8 * n) ? tbytes[b / 8][7 - (b % 8)] : xbits[b - 8 * n];
      sck_pulse(bitv, so, oe);
      sob[b] = so;
      soe[b] = oe;
    end
    wclk(HP);
    chk(m ? "R4" : "R5", "addr_match", addr_match, m);
    csn = 1'b1;
    wclk(6);
    chk("R10", "cs_rise pulses", n_csr - bc, 1);
    chk("R1", "sdo_oe deselected", sdo_oe, 0);
    nb = m ? n : 0;
    chk(m ? "R3" : "R5", "byte strobes", n_rx - br, nb);
    if (n_rx - br == nb) begin
      for (int k = 0; k < nb; k++) begin
        chk(k == 0 ? "R4" : "R3", "rx_byte", mon_b[(br + k) % 256], tbytes[k]);
        chk("R3", "byte_idx", mon_i[(br + k) % 256], k);
      end
    end
    nb = m ? 8 * (n - 1) + extra : 0;
    chk(m ? "R6" : "R5", "bit strobes", n_bits - bb, nb);
    if (n_bits - bb == nb) begin
      for (int k = 0; k < nb; k++) begin
        bitv = (k < 8 * (n - 1)) ? tbytes[1 + k / 8][7 - (k % 8)] : xbits[k - 8 * (n - 1)];
        chk("R6", "bit_val", mon_bits[(bb + k) % 2048], bitv);
      end
    end
    for (int b = 8; b < 8 * n; b++) begin
      if (m) begin
        chk("R7", "sdo_oe at sample", soe[b], 1);
        chk("R7", "sdo bit", sob[b], txd[7 - (b % 8)]);
      end else begin
        chk("R5", "sdo_oe rejected", soe[b], 0);
      end
    end
    wclk(HP);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int br, bb, bc, n, extra, hold_at;
    logic so, oe;
    logic [1:0] st;
    void'($urandom(32'h5EED));
    rst_n = 1'b0; sck = 1'b0; sdi = 1'b0; csn = 1'b0; holdn = 1'b1;
    strap_addr = 2'b00; tx_data = 8'h00;
    wclk(5);
    chk("R1", "sdo_oe in reset", sdo_oe, 0);
    chk("R1", "rx_valid in reset", rx_valid, 0);
    chk("R1", "cs_rise in reset", cs_rise, 0);
    rst_n = 1'b1;
    wclk(4);

    br = n_rx; bb = n_bits; bc = n_csr;
    for (int b = 0; b < 16; b++) sck_pulse(b < 8 ? 1'(8'h50 >> (7 - b)) : 1'b1, so, oe);
    wclk(HP);
    chk("R2", "no strobes before first select edge", n_rx - br, 0);
    chk("R2", "no bit strobes before first select edge", n_bits - bb, 0);
    chk("R2", "no match before first select edge", addr_match, 0);
    csn = 1'b1;
    wclk(HP);
    chk("R2", "no cs_rise without a started selection", n_csr - bc, 0);

    br = n_rx;
    for (int b = 0; b < 8; b++) sck_pulse(1'(8'h50 >> (7 - b)), so, oe);
    wclk(HP);
    chk("R1", "no strobes while deselected", n_rx - br, 0);
    chk("R1", "sdo_oe while deselected", sdo_oe, 0);

    tbytes[0] = 8'h56; tbytes[1] = 8'h3C; tbytes[2] = 8'hC3;
    frame(3, 0, -1, 2'b10, 8'hA5);
    tbytes[0] = 8'h55;
    frame(2, 0, -1, 2'b10, 8'hFF);
    tbytes[0] = 8'h76;
    frame(2, 0, -1, 2'b10, 8'hFF);
    tbytes[0] = 8'h5A;
    frame(2, 0, -1, 2'b10, 8'hFF);
    tbytes[0] = 8'h53; tbytes[1] = 8'h81;
    xbits[0] = 1'b1; xbits[1] = 1'b0; xbits[2] = 1'b1;
    frame(2, 3, -1, 2'b11, 8'h5A);
    tbytes[0] = 8'h51; tbytes[1] = 8'h00; tbytes[2] = 8'hFF;
    frame(3, 0, 12, 2'b01, 8'h96);
    tbytes[0] = 8'h50; tbytes[1] = 8'h6E;
    frame(2, 0, 8, 2'b00, 8'h3B);

    for (int f = 0; f < 24; f++) begin
      st = 2'($urandom);
      n = 1 + $urandom % 5;
      extra = ($urandom % 2 == 0) ? 0 : $urandom % 8;
      tbytes[0] = ($urandom % 3 != 0) ? {4'b0101, 2'b00, st} : 8'($urandom);
      for (int k = 1; k < n; k++) tbytes[k] = 8'($urandom);
      for (int k = 0; k < 8; k++) xbits[k] = 1'($urandom);
      hold_at = ($urandom % 3 == 0) ? 1 + $urandom % (8 * n + extra) : -1;
      if (hold_at >= 8 * n + extra) hold_at = -1;
      frame(n, extra, hold_at, st, 8'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule